// File: doc/BRIEF.md
# Packed Sliding-Window Line Buffer

This block converts a raster-ordered pixel stream into a complete two-dimensional window for a downstream window-processing datapath. Every accepted beat carries several horizontally adjacent pixels packed into one word. The number of pixels per word is the packing factor. The block stores earlier image lines in delay lines. It also exposes every window position at once through parallel-output tap registers.

There is one row lane for each window row, and each row lane is split into one pixel lane per packed position. Row 0 is fed directly from the input word. Each later row is fed through a line-delay FIFO that holds the previous row's stream back by exactly one image line. Each delay FIFO is a dual-port memory that is read and written on the same beat. The FIFOs are steered by one read counter and one write counter, and all FIFOs share them. Both counters advance only on a beat where the input is valid. When the input is not valid, the whole buffer freezes.

A window-valid flag rises once enough beats have been accepted to fill every row lane and every tap stage. It then stays high until reset. Reset is synchronous. It clears the counters, the tap registers and the flag, but it leaves the FIFO memories untouched. Image borders, template weights and the window arithmetic are handled elsewhere.

Top module: `packed_line_buffer`

## Requirements
- R1: In the cycle after a synchronous reset, `winValid` is 0 and every row-0 tap word in `winPix` is zero.
- R2: On each valid beat, row 0 shifts. Stage 0 takes the incoming word and stage s takes the old stage s-1. The word for row r, stage s sits at bit offset ((r*TAP_LEN)+s)*PACK*PIX_W of `winPix`. Inside a word, pixel lane p sits at offset p*PIX_W, and lane 0 is the earliest pixel of the beat.
- R3: Row r, stage s holds the word that row 0, stage s held exactly r*IMG_W/PACK accepted beats earlier, so each row lags its neighbour by one image line.
- R4: `winValid` first reads 1 in the cycle after the accepted beat numbered (WIN_ROWS-1)*IMG_W/PACK + ceil((WIN_COLS+PACK-1)/PACK), counting from reset. It then remains 1 until the next reset.
- R5: A cycle with `inValid` low changes neither `winPix` nor `winValid`, whatever `inData` carries.
- R6: The shared FIFO read and write counters advance only on valid beats. They stay equal, and they wrap from IMG_W/PACK-2 back to 0, which gives a FIFO depth of IMG_W/PACK-1 entries.
- R7: A reset in the middle of a stream drops `winValid` in the next cycle. The fill count then restarts from zero, so R4 applies again to the beats that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a beat whose input word must be captured on this edge |
| inData | input | PACK*PIX_W | Packed input pixels, lane 0 being the earliest in raster order |
| winValid | output | 1 | High once the initial fill is complete |
| winPix | output | WIN_ROWS*TAP_LEN*PACK*PIX_W | All tap words of all row lanes, laid out as given in R2 |

## Verification
Row 0 stage 0 shows an input word one edge after the beat that carries it. Row r shows that same word r*IMG_W/PACK accepted beats later, because the FIFO's registered read adds the last beat of the line delay. `winValid` reads 1 one edge after the beat that completes the fill count, and both the flag and the taps clear one edge after reset. A behavioural model updates on each rising edge from the recorded input history. The outputs are compared with it at every falling edge, so each result is sampled one half cycle after the edge that produces it. Rows above 0 are compared only when the expected word comes from a beat accepted since reset, because the FIFO memories are not cleared.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  // Strobes sent from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;     // capture this beat into every lane
    logic windowFull;  // initial fill complete
  } lbuf_ctrl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int bitsFor(input int maxVal);
    return (maxVal < 2) ? 1 : $clog2(maxVal + 1);
  endfunction

endpackage

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int DEPTH     = 7,
  parameter int FILL_BEATS = 18,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output lbuf_ctrl_t    ctrl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  localparam int FW = bitsFor(FILL_BEATS);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(FILL_BEATS);

  logic [FW-1:0] fillCnt;
  logic [AW-1:0] wrNext;
  logic [AW-1:0] rdNext;

  always_comb begin
    wrNext = (wrAddr == LAST_ADDR) ? '0 : wrAddr + AW'(1);
    rdNext = (rdAddr == LAST_ADDR) ? '0 : rdAddr + AW'(1);
  end

  // Write address counter
  always_ff @(posedge clk) begin
    if (rst) begin
      wrAddr <= '0;
    end else if (inValid) begin
      wrAddr <= wrNext;
    end
  end

  // Read address counter
  always_ff @(posedge clk) begin
    if (rst) begin
      rdAddr <= '0;
    end else if (inValid) begin
      rdAddr <= rdNext;
    end
  end

  // Saturating fill counter
  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (inValid && (fillCnt != FILL_MAX)) begin
      fillCnt <= fillCnt + FW'(1);
    end
  end

  always_comb begin
    ctrl.shiftEn    = inValid;
    ctrl.windowFull = (fillCnt == FILL_MAX);
  end

endmodule

// File: rtl/lbuf_fifo.sv
module lbuf_fifo #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 7,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [PIX_W-1:0] wrData,
  output logic [PIX_W-1:0] rdData
);

  logic [PIX_W-1:0] mem [DEPTH];

  // Storage is never cleared
  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  // Registered read returns the entry before this beat overwrites it
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (wrEn) begin
      rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/lbuf_datapath.sv
module lbuf_datapath
  import lbuf_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int PACK     = 2,
  parameter int WIN_ROWS = 3,
  parameter int TAP_LEN  = 2,
  parameter int DEPTH    = 7,
  parameter int AW       = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  lbuf_ctrl_t                           ctrl,
  input  logic [AW-1:0]                        wrAddr,
  input  logic [AW-1:0]                        rdAddr,
  input  logic [PACK*PIX_W-1:0]                inData,
  output logic [WIN_ROWS*TAP_LEN*PACK*PIX_W-1:0] winPix
);

  localparam int WORD_W = PACK * PIX_W;

  logic [PIX_W-1:0]  laneIn   [WIN_ROWS][PACK];
  logic [PIX_W-1:0]  fifoOut  [WIN_ROWS-1][PACK];
  logic [WORD_W-1:0] rowWord  [WIN_ROWS];
  logic [WORD_W-1:0] taps     [WIN_ROWS][TAP_LEN];

  for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
    for (genvar p = 0; p < PACK; p++) begin : g_lane
      if (r == 0) begin : g_src_input
        assign laneIn[r][p] = inData[p*PIX_W +: PIX_W];
      end else begin : g_src_fifo
        assign laneIn[r][p] = fifoOut[r-1][p];
      end

      if (r < WIN_ROWS - 1) begin : g_delay
        lbuf_fifo #(
          .PIX_W (PIX_W),
          .DEPTH (DEPTH),
          .AW    (AW)
        ) u_fifo (
          .clk    (clk),
          .rst    (rst),
          .wrEn   (ctrl.shiftEn),
          .wrAddr (wrAddr),
          .rdAddr (rdAddr),
          .wrData (laneIn[r][p]),
          .rdData (fifoOut[r][p])
        );
      end

      assign rowWord[r][p*PIX_W +: PIX_W] = laneIn[r][p];
    end

    // Tap shift register with parallel outputs
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < TAP_LEN; s++) begin
          taps[r][s] <= '0;
        end
      end else if (ctrl.shiftEn) begin
        taps[r][0] <= rowWord[r];
        for (int s = 1; s < TAP_LEN; s++) begin
          taps[r][s] <= taps[r][s-1];
        end
      end
    end

    for (genvar s = 0; s < TAP_LEN; s++) begin : g_tap_out
      assign winPix[(r*TAP_LEN + s)*WORD_W +: WORD_W] = taps[r][s];
    end
  end

endmodule

// File: rtl/packed_line_buffer.sv
module packed_line_buffer
  import lbuf_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int PACK     = 2,
  parameter int IMG_W    = 16,
  parameter int WIN_ROWS = 3,
  parameter int WIN_COLS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic [PACK*PIX_W-1:0] inData,
  output logic winValid,
  output logic [WIN_ROWS*lbuf_pkg::ceilDiv(WIN_COLS+PACK-1, PACK)*PACK*PIX_W-1:0] winPix
);

  localparam int LINE_BEATS = IMG_W / PACK;
  localparam int DEPTH      = LINE_BEATS - 1;
  localparam int TAP_LEN    = ceilDiv(WIN_COLS + PACK - 1, PACK);
  localparam int FILL_BEATS = (WIN_ROWS - 1) * LINE_BEATS + TAP_LEN;
  localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lbuf_ctrl_t    ctrl;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  lbuf_ctrl #(
    .DEPTH      (DEPTH),
    .FILL_BEATS (FILL_BEATS),
    .AW         (AW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  lbuf_datapath #(
    .PIX_W    (PIX_W),
    .PACK     (PACK),
    .WIN_ROWS (WIN_ROWS),
    .TAP_LEN  (TAP_LEN),
    .DEPTH    (DEPTH),
    .AW       (AW)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .inData (inData),
    .winPix (winPix)
  );

  assign winValid = ctrl.windowFull;

endmodule

// File: rtl/packed_line_buffer_chk.sv
module packed_line_buffer_chk #(
  parameter int WORD_W = 16,
  parameter int PIX_BITS = 96,
  parameter int DEPTH  = 7,
  parameter int AW     = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [WORD_W-1:0]   inData,
  input logic                winValid,
  input logic [PIX_BITS-1:0] winPix,
  input logic [AW-1:0]       wrAddr,
  input logic [AW-1:0]       rdAddr
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  // R2: newest row-0 stage takes the accepted word
  p_row0_capture_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> winPix[WORD_W-1:0] == $past(inData));

  // R4: flag stays up once set
  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    winValid |=> winValid);

  // R4: flag rises only after an accepted beat
  p_valid_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(winValid) |-> $past(inValid));

  // R5: stall freezes every output
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(winPix) && $stable(winValid)));

  // R6: counters stay within the FIFO depth
  p_addr_range_r6: assert property (@(posedge clk) disable iff (rst)
    wrAddr <= LAST_ADDR);

  // R6: read and write counters agree
  p_addr_agree_r6: assert property (@(posedge clk) disable iff (rst)
    rdAddr == wrAddr);

  // R6: wrap back to entry zero after the last entry
  p_addr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && wrAddr == LAST_ADDR) |=> wrAddr == '0);

  // R6: counter holds during a stall
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(wrAddr));

  // R7: reset drops the flag on the next edge
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> !winValid);

endmodule

bind packed_line_buffer packed_line_buffer_chk #(
  .WORD_W   (PACK*PIX_W),
  .PIX_BITS (WIN_ROWS*TAP_LEN*PACK*PIX_W),
  .DEPTH    (DEPTH),
  .AW       (AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inData   (inData),
  .winValid (winValid),
  .winPix   (winPix),
  .wrAddr   (wrAddr),
  .rdAddr   (rdAddr)
);

// File: tb/packed_line_buffer_tb.sv
module packed_line_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 8;
  localparam int PACK       = 2;
  localparam int IMG_W      = 16;
  localparam int ROWS       = 3;
  localparam int COLS       = 3;
  localparam int WORD_W     = PACK * PIX_W;
  localparam int LINE       = IMG_W / PACK;
  localparam int TAPS       = (COLS + PACK - 1 + PACK - 1) / PACK;
  localparam int FILL       = (ROWS - 1) * LINE + TAPS;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [WORD_W-1:0] inData = '0;
  logic winValid;
  logic [ROWS*TAPS*WORD_W-1:0] winPix;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [WORD_W-1:0] hist[$];
  int beats = 0;
  int resets = 0;
  bit started = 1'b0;
  bit lastStall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_line_buffer #(
    .PIX_W    (PIX_W),
    .PACK     (PACK),
    .IMG_W    (IMG_W),
    .WIN_ROWS (ROWS),
    .WIN_COLS (COLS)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .winValid (winValid),
    .winPix   (winPix)
  );

  // Model update on each rising edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      hist.delete();
      beats = 0;
      resets++;
      lastStall = 1'b0;
    end else begin
      lastStall = !inValid;
      if (inValid) begin
        hist.push_back(inData);
        beats++;
      end
    end
  end

  // Comparison half a cycle after each edge
  always @(negedge clk) begin
    if (started && !finished) begin
      logic expValid;
      expValid = (beats >= FILL);
      checks++;
      if (winValid !== expValid) begin
        fails++;
        if (resets > 1 && beats < FILL)
          $display("FAIL R7 winValid got %0b exp %0b (beats %0d)", winValid, expValid, beats);
        else if (lastStall)
          $display("FAIL R5 winValid got %0b exp %0b (beats %0d)", winValid, expValid, beats);
        else
          $display("FAIL R4 winValid got %0b exp %0b (beats %0d)", winValid, expValid, beats);
      end
      for (int r = 0; r < ROWS; r++) begin
        for (int s = 0; s < TAPS; s++) begin
          int idx;
          logic [WORD_W-1:0] got;
          logic [WORD_W-1:0] exp;
          idx = beats - 1 - s - r * LINE;
          got = winPix[(r*TAPS + s)*WORD_W +: WORD_W];
          if (idx >= 0 || r == 0) begin
            exp = (idx >= 0) ? hist[idx] : '0;
            checks++;
            if (got !== exp) begin
              fails++;
              if (lastStall)
                $display("FAIL R5 row %0d stage %0d got %h exp %h", r, s, got, exp);
              else if (idx < 0)
                $display("FAIL R1 row %0d stage %0d got %h exp %h", r, s, got, exp);
              else if (r == 0)
                $display("FAIL R2 row %0d stage %0d got %h exp %h", r, s, got, exp);
              else
                $display("FAIL R3/R6 row %0d stage %0d got %h exp %h", r, s, got, exp);
            end
          end
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [WORD_W-1:0] d);
    @(negedge clk);
    #1;
    inValid = v;
    inData  = d;
  endtask

  task automatic doReset(input int cycles);
    @(negedge clk);
    #1;
    rst = 1'b1;
    inValid = 1'b0;
    repeat (cycles) @(negedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d cycles, got hang exp completion", WATCHDOG);
    endRun();
  end

  initial begin
    // R1: reset state
    doReset(3);
    // R2, R4: continuous stream with counting pattern past the fill point
    for (int i = 0; i < 3 * LINE + 5; i++) begin
      drive(1'b1, WORD_W'(16'h0101 * (i + 1)));
    end
    // R5: stall with data toggling
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, WORD_W'($urandom));
    end
    // R3, R6: long run with irregular holes, many counter wraps
    for (int i = 0; i < 150; i++) begin
      drive(($urandom % 3) != 0, WORD_W'($urandom));
    end
    // R7: reset in mid-stream, then refill with holes
    doReset(1);
    for (int i = 0; i < FILL - 1; i++) begin
      drive(1'b1, WORD_W'($urandom));
      drive(1'b0, WORD_W'($urandom));
    end
    // final beat that completes the fill (R4 boundary)
    drive(1'b1, WORD_W'($urandom));
    for (int i = 0; i < 60; i++) begin
      drive(($urandom % 4) != 0, WORD_W'($urandom));
    end
    drive(1'b0, '0);
    repeat (4) @(negedge clk);
    #1;
    endRun();
  end

endmodule